// File: doc/BRIEF.md
# Superscalar Instruction Issue Window

This block is the issue stage of a superscalar pipeline that issues straight to its execution ports, with no reservation stations in between. It holds up to W decoded instructions, taken one per cycle in program order from an instruction queue. Each instruction names one destination register and two source registers. Every cycle it tests each held instruction for dependencies against a per-register busy scoreboard and against the older instructions still in the window. It then issues up to W of them on W slot outputs, one per execution port. A writeback port clears the busy bit of a register whose result has arrived.

Two compile-time switches set the policy. `IN_ORDER` decides whether a blocked instruction also holds back every younger one, or lets independent younger ones go past it. `ALIGNED` decides how the window refills. With it set, the window is a fixed group: it loads, closes and drains completely before the next group may enter. With it clear, the window glides: the survivors shift toward slot 0 and new instructions enter every cycle in which room opens.

Top module: `issue_window`

## Requirements
- R1: At most W instructions issue per cycle. Slot 0 always holds the oldest instruction, and the slots hold the remaining instructions in program order. The `iss_*` fields of slot i carry the registers of the instruction held in slot i.
- R2: An instruction does not issue while its destination or either source register is busy. Issue sets the destination's busy bit. A writeback clears the bit, and the dependency check sees the cleared bit only from the following cycle. If a writeback and an issue name the same register in one cycle, the bit ends up set.
- R3: With `IN_ORDER`=1, the oldest instruction that cannot issue also stops every younger instruction in the window, so the issuing slots always form a prefix of slots 0, 1, 2, and so on.
- R4: With `IN_ORDER`=0, a younger independent instruction may issue while an older one waits. A younger instruction still waits if an older instruction in the window reads the register it writes.
- R5: With `ALIGNED`=1, `in_ready` is high only while the group is open and the window is not full. Nothing issues while the group is open. The group closes when the window becomes full, or when `in_valid` is low while the window is not empty. It reopens only once every instruction in it has issued.
- R6: With `ALIGNED`=0, `in_ready` is high whenever at least one slot will be free after this cycle's issue. The survivors move toward slot 0 in order, and the accepted instruction lands in the first free slot behind them.
- R7: A younger instruction never issues in the same cycle as an older instruction in the window whose destination equals one of its own sources or its destination. The older instruction's destination counts as already busy.
- R8: Reset empties the window, clears every busy bit and reopens the group, so afterwards `iss_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is offered by the queue |
| in_ready | output | 1 | The window takes the offered instruction at this edge |
| in_dst | input | RW | Destination register of the offered instruction |
| in_src1 | input | RW | First source register |
| in_src2 | input | RW | Second source register |
| iss_valid | output | W | Bit i: slot i issues this cycle |
| iss_dst | output | W*RW | Destination of slot i at bits [i*RW +: RW] |
| iss_src1 | output | W*RW | First source of slot i |
| iss_src2 | output | W*RW | Second source of slot i |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_reg | input | RW | Register whose busy bit is cleared |

## Verification
The bench runs all four policy combinations side by side. A small register file makes hazards frequent, and a cycle-level model in the bench predicts the issue mask and `in_ready` of each one. A directed opening checks three cases: a read-after-write chain between neighbouring slots, which a design missing the same-cycle check would issue together; an independent instruction behind a blocked one, which an in-order design must hold and an out-of-order design must release; and a write-after-write pair. Random writebacks land in the same cycle as issues to the same register. A design that let the writeback win, or that let a writeback reach the dependency check one cycle early, would drift from the model. A reset in the middle of the run catches leftover busy bits or a group left closed. In the gliding configurations, the slot fields of the issued instructions expose any compaction that reorders the survivors or drops an accepted instruction.

// File: rtl/issue_window.sv
module issue_window #(
  parameter int W = 4,
  parameter int NREG = 32,
  parameter bit IN_ORDER = 1'b1,
  parameter bit ALIGNED = 1'b1,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [RW-1:0]   in_dst,
  input  logic [RW-1:0]   in_src1,
  input  logic [RW-1:0]   in_src2,
  output logic [W-1:0]    iss_valid,
  output logic [W*RW-1:0] iss_dst,
  output logic [W*RW-1:0] iss_src1,
  output logic [W*RW-1:0] iss_src2,
  input  logic            wb_valid,
  input  logic [RW-1:0]   wb_reg
);

  logic [W-1:0]    v, v_n, dep, iss;
  logic [RW-1:0]   sd [W];
  logic [RW-1:0]   s1 [W];
  logic [RW-1:0]   s2 [W];
  logic [RW-1:0]   sd_n [W];
  logic [RW-1:0]   s1_n [W];
  logic [RW-1:0]   s2_n [W];
  logic [NREG-1:0] busy, busy_n;
  logic            closed, closed_n, go, acc;
  int              cnt, left;

  always_comb begin : hazard
    dep = '0;
    for (int i = 0; i < W; i++) begin
      dep[i] = busy[s1[i]] | busy[s2[i]] | busy[sd[i]];
      for (int j = 0; j < i; j++) begin
        if (v[j]) begin
          if (sd[j] == s1[i] || sd[j] == s2[i] || sd[j] == sd[i]) dep[i] = 1'b1;
          if (!IN_ORDER && (s1[j] == sd[i] || s2[j] == sd[i])) dep[i] = 1'b1;
        end
      end
    end
  end

  assign go = ALIGNED ? closed : 1'b1;

  always_comb begin : pick
    logic blk;
    blk = 1'b0;
    iss = '0;
    cnt = 0;
    left = 0;
    for (int i = 0; i < W; i++) begin
      iss[i] = go & v[i] & ~dep[i] & ~blk;
      if (IN_ORDER && v[i] && !iss[i]) blk = 1'b1;
      if (v[i]) cnt++;
      if (v[i] && !iss[i]) left++;
    end
  end

  assign in_ready = ALIGNED ? (!closed && cnt < W) : (left < W);
  assign acc = in_valid & in_ready;

  always_comb begin : nxt
    int k;
    k = 0;
    v_n = '0;
    busy_n = busy;
    for (int i = 0; i < W; i++) begin
      sd_n[i] = sd[i];
      s1_n[i] = s1[i];
      s2_n[i] = s2[i];
    end
    if (wb_valid) busy_n[wb_reg] = 1'b0;
    for (int i = 0; i < W; i++)
      if (iss[i]) busy_n[sd[i]] = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (v[i] && !iss[i]) begin
        v_n[k]  = 1'b1;
        sd_n[k] = sd[i];
        s1_n[k] = s1[i];
        s2_n[k] = s2[i];
        k++;
      end
    end
    if (acc && k < W) begin
      v_n[k]  = 1'b1;
      sd_n[k] = in_dst;
      s1_n[k] = in_src1;
      s2_n[k] = in_src2;
    end
    if (!ALIGNED)   closed_n = 1'b0;
    else if (closed) closed_n = (left != 0);
    else             closed_n = (cnt + (acc ? 1 : 0) == W) || (!in_valid && cnt != 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v <= '0;
      busy <= '0;
      closed <= 1'b0;
      for (int i = 0; i < W; i++) begin
        sd[i] <= '0;
        s1[i] <= '0;
        s2[i] <= '0;
      end
    end else begin
      v <= v_n;
      busy <= busy_n;
      closed <= closed_n;
      for (int i = 0; i < W; i++) begin
        sd[i] <= sd_n[i];
        s1[i] <= s1_n[i];
        s2[i] <= s2_n[i];
      end
    end
  end

  assign iss_valid = iss;

  for (genvar i = 0; i < W; i++) begin : g_out
    assign iss_dst[i*RW +: RW]  = sd[i];
    assign iss_src1[i*RW +: RW] = s1[i];
    assign iss_src2[i*RW +: RW] = s2[i];
  end

  // Checks on the block's own behaviour
  logic dup, wb_hit;
  always_comb begin
    dup = 1'b0;
    wb_hit = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (iss[i] && wb_valid && sd[i] == wb_reg) wb_hit = 1'b1;
      for (int j = 0; j < i; j++)
        if (iss[i] && iss[j] && sd[i] == sd[j]) dup = 1'b1;
    end
  end

  p_no_twin_dst_r7: assert property (@(posedge clk) disable iff (!rst_n) !dup);

  p_wb_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_hit |=> !busy[$past(wb_reg)]);

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_issue_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iss[i] |=> busy[$past(sd[i])]);
    if (i > 0) begin : g_pair
      p_packed_slots_r1: assert property (@(posedge clk) disable iff (!rst_n)
        v[i] |-> v[i-1]);
      if (IN_ORDER) begin : g_ino
        p_prefix_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
          iss_valid[i] |-> iss_valid[i-1]);
      end
    end
  end

  if (ALIGNED) begin : g_aln
    p_closed_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      closed |-> !in_ready);
    p_open_no_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> iss_valid == '0);
  end else begin : g_glide
    p_take_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> v != '0);
  end

endmodule

// File: tb/issue_window_test.sv
module issue_window_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int NREG = 8;
  localparam int RW = 3;
  localparam int NS = 1200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int checks = 0;
  int fails = 0;

  logic [RW-1:0] st_d [NS];
  logic [RW-1:0] st_a [NS];
  logic [RW-1:0] st_b [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    void'($urandom(32'd7411));
    for (int n = 0; n < NS; n++) begin
      st_d[n] = RW'($urandom % NREG);
      st_a[n] = RW'($urandom % NREG);
      st_b[n] = RW'($urandom % NREG);
    end
    // directed opening: RAW chain, independent behind blocked, WAW
    st_d[0] = 3'd1; st_a[0] = 3'd2; st_b[0] = 3'd3;
    st_d[1] = 3'd4; st_a[1] = 3'd1; st_b[1] = 3'd1;
    st_d[2] = 3'd5; st_a[2] = 3'd6; st_b[2] = 3'd7;
    st_d[3] = 3'd1; st_a[3] = 3'd5; st_b[3] = 3'd5;
    st_d[4] = 3'd2; st_a[4] = 3'd0; st_b[4] = 3'd0;
    st_d[5] = 3'd3; st_a[5] = 3'd2; st_b[5] = 3'd6;
  end

  for (genvar g = 0; g < 4; g++) begin : cfg
    localparam bit INO = (g % 2) == 1;
    localparam bit ALN = g >= 2;

    logic in_valid = 1'b0;
    logic in_ready;
    logic [RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [W-1:0] iss_valid;
    logic [W*RW-1:0] iss_dst, iss_src1, iss_src2;
    logic wb_valid = 1'b0;
    logic [RW-1:0] wb_reg = '0;

    issue_window #(.W(W), .NREG(NREG), .IN_ORDER(INO), .ALIGNED(ALN)) uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
      .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
      .wb_valid(wb_valid), .wb_reg(wb_reg));

    bit mv [W];
    logic [RW-1:0] md [W];
    logic [RW-1:0] m1 [W];
    logic [RW-1:0] m2 [W];
    bit mbusy [NREG];
    bit mclosed;
    int ptr;

    initial ptr = 0;

    always @(negedge clk) begin : step
      logic [W-1:0] ex;
      bit go, blk, dp, rdy, acc;
      int cnt, nis, k;
      logic [RW-1:0] r;
      bit nv [W];
      logic [RW-1:0] nd [W];
      logic [RW-1:0] n1 [W];
      logic [RW-1:0] n2 [W];
      if (!rst_n) begin
        for (int i = 0; i < W; i++) mv[i] = 0;
        for (int i = 0; i < NREG; i++) mbusy[i] = 0;
        mclosed = 0;
        in_valid = 1'b0;
        wb_valid = 1'b0;
        #1;
        check("R8", "iss_valid in reset", int'(iss_valid), 0);
        check("R8", "in_ready in reset", int'(in_ready), 1);
      end else begin
        go = ALN ? mclosed : 1'b1;
        blk = 0; ex = '0; cnt = 0; nis = 0;
        for (int i = 0; i < W; i++) begin
          dp = mbusy[md[i]] || mbusy[m1[i]] || mbusy[m2[i]];
          for (int j = 0; j < i; j++)
            if (mv[j] && (md[j] == md[i] || md[j] == m1[i] || md[j] == m2[i] ||
                          (!INO && (m1[j] == md[i] || m2[j] == md[i])))) dp = 1;
          ex[i] = mv[i] && go && !dp && !blk;
          if (INO && mv[i] && !ex[i]) blk = 1;
          if (mv[i]) cnt++;
          if (ex[i]) nis++;
        end
        rdy = ALN ? (!mclosed && cnt < W) : (cnt - nis < W);

        in_valid = (ptr < 6) || (ptr < NS && ($urandom % 8) != 0);
        in_dst  = st_d[ptr < NS ? ptr : 0];
        in_src1 = st_a[ptr < NS ? ptr : 0];
        in_src2 = st_b[ptr < NS ? ptr : 0];
        wb_valid = 1'b0;
        r = RW'($urandom % NREG);
        if (($urandom % 3) != 0) begin
          for (int t = 0; t < 4; t++)
            if (!mbusy[r]) r = RW'($urandom % NREG);
          wb_valid = 1'b1;
        end
        wb_reg = r;
        #1;
        check("R1", "issue count", $countones(iss_valid), nis);
        check(INO ? "R3 R2 R7" : "R4 R2 R7", "issue mask", int'(iss_valid), int'(ex));
        check(ALN ? "R5" : "R6", "in_ready", int'(in_ready), int'(rdy));
        for (int i = 0; i < W; i++)
          if (ex[i]) begin
            check("R1 R6", "slot dst", int'(iss_dst[i*RW +: RW]), int'(md[i]));
            check("R1 R6", "slot srcs", int'({iss_src1[i*RW +: RW], iss_src2[i*RW +: RW]}),
                  int'({m1[i], m2[i]}));
          end

        acc = in_valid && rdy;
        if (wb_valid) mbusy[wb_reg] = 0;
        for (int i = 0; i < W; i++) if (ex[i]) mbusy[md[i]] = 1;
        k = 0;
        for (int i = 0; i < W; i++) begin
          nv[i] = 0; nd[i] = '0; n1[i] = '0; n2[i] = '0;
        end
        for (int i = 0; i < W; i++)
          if (mv[i] && !ex[i]) begin
            nv[k] = 1; nd[k] = md[i]; n1[k] = m1[i]; n2[k] = m2[i]; k++;
          end
        if (acc) begin
          nv[k] = 1; nd[k] = in_dst; n1[k] = in_src1; n2[k] = in_src2;
          ptr++;
        end
        if (!ALN) mclosed = 0;
        else if (mclosed) mclosed = (cnt - nis) != 0;
        else mclosed = (cnt + (acc ? 1 : 0) == W) || (!in_valid && cnt != 0);
        for (int i = 0; i < W; i++) begin
          mv[i] = nv[i]; md[i] = nd[i]; m1[i] = n1[i]; m2[i] = n2[i];
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (700) @(posedge clk);
    #2 rst_n = 1'b0;   // mid-run reset, R8
    @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (700) @(posedge clk);
    #2;
    summary();
    $finish;
  end
endmodule